// File: doc/BRIEF.md
# FIFO Ready-Pin Generator with Single and Block Transfer Modes

This block produces the two active-low status pins that tell an external transfer engine when one UART channel wants service: a receive-ready pin and a transmit-ready pin. It keeps its own occupancy count for the receive FIFO and for the transmit FIFO. It follows push and pop strobes from the FIFO datapath, and it decides from those counts when each pin is asserted.

A mode input picks one of two pin disciplines. In single-transfer mode each pin simply reflects whether its FIFO is empty. In block mode the receive pin has hysteresis: it asserts once a trigger level is reached or a timeout fires, and it stays asserted until the FIFO is drained. The transmit pin rises only when the FIFO is completely full. FIFO capacity is 32 entries. It widens to 128 entries whenever any of four 8-bit level or threshold configuration values is nonzero.

Top module: `fifo_ready_pins`

## Requirements
- R1: While reset is held and after it is released, both counts read 0, `rx_rdy_n` reads 1 and `tx_rdy_n` reads 0.
- R2: A push strobe raises a count by one and a pop strobe lowers it by one, visible on the count output after the next rising clock edge. When a push and a pop are both accepted in the same cycle, the count is unchanged.
- R3: Capacity is 32 when all four configuration inputs are zero and 128 when any of them is nonzero. A push is accepted only while the count is below capacity, so a push at or above capacity leaves the count unchanged.
- R4: A pop while the count is 0 is ignored, and the count stays 0.
- R5: `blk_mode` = 0 selects single-transfer rules and `blk_mode` = 1 selects block rules. With the same receive count below the trigger level, the receive pin differs between the two modes.
- R6: In single-transfer mode, `rx_rdy_n` is 0 when the receive count was nonzero at the previous edge and 1 when it was zero.
- R7: In single-transfer mode, `tx_rdy_n` is 1 when the transmit count was nonzero at the previous edge and 0 when it was zero.
- R8: In block mode, `rx_rdy_n` falls one edge after a cycle in which the receive count is nonzero and is either at least `rx_trig` (unsigned compare) or accompanied by an `rx_timeout` pulse.
- R9: In block mode, once low, `rx_rdy_n` stays low until a cycle in which the receive count is 0. It returns to 1 at the following edge.
- R10: In block mode, `tx_rdy_n` is 1 exactly when the transmit count at the previous edge was at or above capacity, and it returns to 0 once one location is free.
- R11: An `rx_timeout` pulse while the receive count is 0 does not assert `rx_rdy_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_mode | input | 1 | 0 = single-transfer rules, 1 = block rules |
| cfg_tx_lvl | input | 8 | Transmit level setting; nonzero enables 128-entry capacity |
| cfg_rx_lvl | input | 8 | Receive level setting; nonzero enables 128-entry capacity |
| cfg_flow_hi | input | 8 | Flow-control upper threshold; nonzero enables 128-entry capacity |
| cfg_flow_lo | input | 8 | Flow-control lower threshold; nonzero enables 128-entry capacity |
| rx_trig | input | 8 | Receive trigger level for block mode |
| rx_timeout | input | 1 | Single-cycle receive timeout pulse |
| rx_push | input | 1 | A byte was written into the receive FIFO |
| rx_pop | input | 1 | A byte was read from the receive FIFO |
| tx_push | input | 1 | A byte was written into the transmit FIFO |
| tx_pop | input | 1 | A byte was taken from the transmit FIFO |
| rx_count | output | 8 | Receive FIFO occupancy |
| tx_count | output | 8 | Transmit FIFO occupancy |
| rx_rdy_n | output | 1 | Active-low receive-ready pin |
| tx_rdy_n | output | 1 | Active-low transmit-ready pin |

## Verification
Directed sequences fill each FIFO past 32 with the configuration zero and then past 128 with it nonzero. They drain the receive FIFO past empty and walk the receive count up to the trigger level and back down in block mode. This separates capacity clipping and hysteretic hold from plain empty detection. A timeout pulse is applied once with an empty FIFO and once with data below the trigger, which separates the timeout path from the level path. Random strobes with occasional changes of mode, trigger and configuration then mix simultaneous push/pop, mode switches in mid-hold and capacity shrinking below the current count. A bench model compares every cycle.

// File: rtl/rdy_pkg.sv
// Package: shared mode type for the ready-pin generator.
// Assumes: nothing beyond standard SystemVerilog.
package rdy_pkg;

    typedef enum logic {
        XFER_SINGLE = 1'b0,
        XFER_BLOCK  = 1'b1
    } xfer_mode_e;

endpackage

// File: rtl/rdy_occ_counter.sv
// Module: occupancy counter for one FIFO.
// Counts accepted pushes and pops. A push is accepted only below the
// capacity and a pop only when nonzero. Flags full (count at or above
// capacity) and empty.
// Assumes: cap fits in CW bits; strobes are synchronous to clk.
module rdy_occ_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [CW-1:0] cap,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic push_ok;
    logic pop_ok;

    // Qualify strobes against the current occupancy.
    always_comb begin
        push_ok = push && (count < cap);
        pop_ok  = pop && (count != '0);
    end

    // Update the occupancy from the accepted strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Derive the status flags.
    always_comb begin
        full  = (count >= cap);
        empty = (count == '0);
    end

endmodule

// File: rtl/rdy_cap_sel.sv
// Module: FIFO capacity selection.
// Chooses the extended depth when any configuration byte is nonzero,
// otherwise the normal depth.
// Assumes: both depths fit in CW bits.
module rdy_cap_sel #(
    parameter int CW         = 8,
    parameter int CFG_W      = 8,
    parameter int NCFG       = 4,
    parameter int DEPTH_NORM = 32,
    parameter int DEPTH_EXT  = 128
) (
    input  logic [NCFG-1:0][CFG_W-1:0] cfg,
    output logic [CW-1:0]              cap
);

    logic [NCFG-1:0] nz;

    genvar gi;
    generate
        for (gi = 0; gi < NCFG; gi++) begin : g_nz
            // Flag a nonzero configuration byte.
            assign nz[gi] = |cfg[gi];
        end
    endgenerate

    // Pick the depth from the extended-mode flag.
    always_comb begin
        cap = (|nz) ? CW'(DEPTH_EXT) : CW'(DEPTH_NORM);
    end

endmodule

// File: rtl/rdy_rx_pin.sv
// Module: receive-ready pin register.
// Single mode: low while data is present. Block mode: falls on the
// trigger level or a timeout with data, and rises only when empty.
// Assumes: count and empty come from the registered counter.
module rdy_rx_pin
    import rdy_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  xfer_mode_e    mode,
    input  logic [CW-1:0] count,
    input  logic          empty,
    input  logic [CW-1:0] trig,
    input  logic          timeout,
    output logic          rdy_n
);

    // Compute the next pin level under the selected discipline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_n <= 1'b1;
        end else if (mode == XFER_SINGLE) begin
            rdy_n <= empty;
        end else if (empty) begin
            rdy_n <= 1'b1;
        end else if ((count >= trig) || timeout) begin
            rdy_n <= 1'b0;
        end
    end

endmodule

// File: rtl/rdy_tx_pin.sv
// Module: transmit-ready pin register.
// Single mode: high while data is present. Block mode: high only when
// the FIFO is full, low once one slot is free.
// Assumes: full and empty come from the registered counter.
module rdy_tx_pin
    import rdy_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  xfer_mode_e mode,
    input  logic       full,
    input  logic       empty,
    output logic       rdy_n
);

    // Compute the next pin level under the selected discipline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_n <= 1'b0;
        end else if (mode == XFER_SINGLE) begin
            rdy_n <= !empty;
        end else begin
            rdy_n <= full;
        end
    end

endmodule

// File: rtl/fifo_ready_pins.sv
// Module: ready-pin generator for one UART channel (top).
// Tracks receive and transmit FIFO occupancy, selects capacity from the
// extended-mode configuration, and drives both active-low ready pins.
// Assumes: push/pop strobes mirror the FIFO datapath; rx_timeout is a
// single-cycle pulse.
module fifo_ready_pins
    import rdy_pkg::*;
#(
    parameter int CFG_W      = 8,
    parameter int DEPTH_NORM = 32,
    parameter int DEPTH_EXT  = 128,
    localparam int CW        = $clog2(DEPTH_EXT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blk_mode,
    input  logic [CFG_W-1:0] cfg_tx_lvl,
    input  logic [CFG_W-1:0] cfg_rx_lvl,
    input  logic [CFG_W-1:0] cfg_flow_hi,
    input  logic [CFG_W-1:0] cfg_flow_lo,
    input  logic [CW-1:0] rx_trig,
    input  logic          rx_timeout,
    input  logic          rx_push,
    input  logic          rx_pop,
    input  logic          tx_push,
    input  logic          tx_pop,
    output logic [CW-1:0] rx_count,
    output logic [CW-1:0] tx_count,
    output logic          rx_rdy_n,
    output logic          tx_rdy_n
);

    localparam int NCFG = 4;

    logic [NCFG-1:0][CFG_W-1:0] cfg_bus;
    logic [CW-1:0]              cap;
    xfer_mode_e                 mode;
    logic                       rx_full, rx_empty;
    logic                       tx_full, tx_empty;

    // Gather configuration bytes and decode the mode.
    always_comb begin
        cfg_bus = {cfg_flow_lo, cfg_flow_hi, cfg_rx_lvl, cfg_tx_lvl};
        mode    = blk_mode ? XFER_BLOCK : XFER_SINGLE;
    end

    rdy_cap_sel #(
        .CW(CW), .CFG_W(CFG_W), .NCFG(NCFG),
        .DEPTH_NORM(DEPTH_NORM), .DEPTH_EXT(DEPTH_EXT)
    ) u_cap (
        .cfg (cfg_bus),
        .cap (cap)
    );

    rdy_occ_counter #(.CW(CW)) u_rx_cnt (
        .clk (clk), .rst_n (rst_n), .push (rx_push), .pop (rx_pop),
        .cap (cap), .count (rx_count), .full (rx_full), .empty (rx_empty)
    );

    rdy_occ_counter #(.CW(CW)) u_tx_cnt (
        .clk (clk), .rst_n (rst_n), .push (tx_push), .pop (tx_pop),
        .cap (cap), .count (tx_count), .full (tx_full), .empty (tx_empty)
    );

    rdy_rx_pin #(.CW(CW)) u_rx_pin (
        .clk (clk), .rst_n (rst_n), .mode (mode), .count (rx_count),
        .empty (rx_empty), .trig (rx_trig), .timeout (rx_timeout),
        .rdy_n (rx_rdy_n)
    );

    rdy_tx_pin u_tx_pin (
        .clk (clk), .rst_n (rst_n), .mode (mode), .full (tx_full),
        .empty (tx_empty), .rdy_n (tx_rdy_n)
    );

    // rx_full is kept for symmetry; fold it into a harmless use.
    logic unused_ok;
    always_comb unused_ok = rx_full;

endmodule

// File: rtl/rdy_checker.sv
// Module: property checker for fifo_ready_pins, attached by bind.
// Assumes: the default 8-bit configuration and count widths.
module rdy_checker #(
    parameter int CW         = 8,
    parameter int CFG_W      = 8,
    parameter int DEPTH_NORM = 32,
    parameter int DEPTH_EXT  = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             blk_mode,
    input logic [CFG_W-1:0] cfg_tx_lvl,
    input logic [CFG_W-1:0] cfg_rx_lvl,
    input logic [CFG_W-1:0] cfg_flow_hi,
    input logic [CFG_W-1:0] cfg_flow_lo,
    input logic [CW-1:0]    rx_trig,
    input logic             rx_timeout,
    input logic             rx_push,
    input logic             rx_pop,
    input logic             tx_push,
    input logic             tx_pop,
    input logic [CW-1:0]    rx_count,
    input logic [CW-1:0]    tx_count,
    input logic             rx_rdy_n,
    input logic             tx_rdy_n
);

    logic [CW-1:0] cap_c;
    // Expected capacity from the configuration ports.
    always_comb cap_c = (|{cfg_tx_lvl, cfg_rx_lvl, cfg_flow_hi, cfg_flow_lo})
                        ? CW'(DEPTH_EXT) : CW'(DEPTH_NORM);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_pop && rx_count >= cap_c) |=> $stable(rx_count));

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && !tx_push && tx_count == '0) |=> (tx_count == '0));

    p_single_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_mode && rx_count == '0) |=> rx_rdy_n);

    p_single_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_mode && tx_count != '0) |=> tx_rdy_n);

    p_block_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_mode && !rx_rdy_n && rx_count != '0) |=> !rx_rdy_n);

    p_block_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_mode && rx_count == '0) |=> rx_rdy_n);

    p_block_tx_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_mode && tx_count >= cap_c) |=> tx_rdy_n);

    p_timeout_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_mode && rx_timeout && rx_count == '0) |=> rx_rdy_n);

endmodule

bind fifo_ready_pins rdy_checker #(
    .CW(CW), .CFG_W(CFG_W), .DEPTH_NORM(DEPTH_NORM), .DEPTH_EXT(DEPTH_EXT)
) u_rdy_checker (
    .clk (clk), .rst_n (rst_n), .blk_mode (blk_mode),
    .cfg_tx_lvl (cfg_tx_lvl), .cfg_rx_lvl (cfg_rx_lvl),
    .cfg_flow_hi (cfg_flow_hi), .cfg_flow_lo (cfg_flow_lo),
    .rx_trig (rx_trig), .rx_timeout (rx_timeout),
    .rx_push (rx_push), .rx_pop (rx_pop),
    .tx_push (tx_push), .tx_pop (tx_pop),
    .rx_count (rx_count), .tx_count (tx_count),
    .rx_rdy_n (rx_rdy_n), .tx_rdy_n (tx_rdy_n)
);

// File: tb/tb_fifo_ready_pins.sv
module tb_fifo_ready_pins;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       blk_mode;
    logic [7:0] cfg_tx_lvl, cfg_rx_lvl, cfg_flow_hi, cfg_flow_lo;
    logic [7:0] rx_trig;
    logic       rx_timeout, rx_push, rx_pop, tx_push, tx_pop;
    logic [7:0] rx_count, tx_count;
    logic       rx_rdy_n, tx_rdy_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // bench model state
    int m_rx, m_tx;
    bit m_rxn, m_txn;

    always #10 clk = ~clk;

    fifo_ready_pins dut (
        .clk (clk), .rst_n (rst_n), .blk_mode (blk_mode),
        .cfg_tx_lvl (cfg_tx_lvl), .cfg_rx_lvl (cfg_rx_lvl),
        .cfg_flow_hi (cfg_flow_hi), .cfg_flow_lo (cfg_flow_lo),
        .rx_trig (rx_trig), .rx_timeout (rx_timeout),
        .rx_push (rx_push), .rx_pop (rx_pop),
        .tx_push (tx_push), .tx_pop (tx_pop),
        .rx_count (rx_count), .tx_count (tx_count),
        .rx_rdy_n (rx_rdy_n), .tx_rdy_n (tx_rdy_n)
    );

    function automatic int cap_f();
        return ((cfg_tx_lvl | cfg_rx_lvl | cfg_flow_hi | cfg_flow_lo) != 0)
               ? 128 : 32;
    endfunction

    function automatic int next_cnt(int c, bit push, bit pop, int cap);
        bit pu = push && (c < cap);
        bit po = pop && (c > 0);
        return c + int'(pu) - int'(po);
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // One clock cycle: drive at the current negedge, model at the posedge,
    // compare at the next negedge.
    task automatic step(bit rpu, bit rpo, bit tpu, bit tpo, bit to);
        int cap;
        rx_push = rpu; rx_pop = rpo; tx_push = tpu; tx_pop = tpo; rx_timeout = to;
        @(posedge clk);
        cap = cap_f();
        if (!blk_mode) begin
            m_rxn = (m_rx == 0);
            m_txn = (m_tx != 0);
        end else begin
            if (m_rx == 0) m_rxn = 1;
            else if (m_rx >= int'(rx_trig) || to) m_rxn = 0;
            m_txn = (m_tx >= cap);
        end
        m_rx = next_cnt(m_rx, rpu, rpo, cap);
        m_tx = next_cnt(m_tx, tpu, tpo, cap);
        @(negedge clk);
        chk("R2 rx_count", int'(rx_count), m_rx);
        chk("R2 tx_count", int'(tx_count), m_tx);
        chk(blk_mode ? "R8 R9 rx_rdy_n" : "R6 rx_rdy_n", int'(rx_rdy_n), int'(m_rxn));
        chk(blk_mode ? "R10 tx_rdy_n" : "R7 tx_rdy_n", int'(tx_rdy_n), int'(m_txn));
        rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0; rx_timeout = 0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 0; blk_mode = 0;
        cfg_tx_lvl = 0; cfg_rx_lvl = 0; cfg_flow_hi = 0; cfg_flow_lo = 0;
        rx_trig = 8'd4;
        rx_timeout = 0; rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
        m_rx = 0; m_tx = 0; m_rxn = 1; m_txn = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: values while reset is held
        chk("R1 rx_count", int'(rx_count), 0);
        chk("R1 rx_rdy_n", int'(rx_rdy_n), 1);
        chk("R1 tx_rdy_n", int'(tx_rdy_n), 0);
        rst_n = 1;
        step(0, 0, 0, 0, 0);
        chk("R1 tx_count", int'(tx_count), 0);

        // R2 / R6: single push, pin follows one edge later
        step(1, 0, 0, 0, 0);
        chk("R2 push", int'(rx_count), 1);
        step(0, 0, 0, 0, 0);
        chk("R6 data present", int'(rx_rdy_n), 0);
        step(1, 1, 0, 0, 0);
        chk("R2 push+pop", int'(rx_count), 1);

        // R3: fill both past normal capacity
        for (int i = 0; i < 40; i++) step(1, 0, 1, 0, 0);
        chk("R3 rx cap 32", int'(rx_count), 32);
        chk("R3 tx cap 32", int'(tx_count), 32);
        step(0, 0, 0, 0, 0);
        chk("R7 tx data present", int'(tx_rdy_n), 1);

        // R3: extended capacity
        cfg_flow_lo = 8'h01;
        for (int i = 0; i < 110; i++) step(1, 0, 0, 0, 0);
        chk("R3 rx cap 128", int'(rx_count), 128);
        cfg_flow_lo = 8'h00;
        step(1, 0, 0, 0, 0);
        chk("R3 shrink blocks push", int'(rx_count), 128);

        // R4: drain past empty
        for (int i = 0; i < 135; i++) step(0, 1, 0, 1, 0);
        chk("R4 rx empty pop", int'(rx_count), 0);
        chk("R4 tx empty pop", int'(tx_count), 0);
        step(0, 0, 0, 0, 0);
        chk("R7 tx empty", int'(tx_rdy_n), 0);

        // R5/R8/R9: block mode hysteresis with trigger 4
        blk_mode = 1; rx_trig = 8'd4;
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        chk("R5 block below trigger", int'(rx_rdy_n), 1);
        blk_mode = 0;
        step(0, 0, 0, 0, 0);
        chk("R5 single same count", int'(rx_rdy_n), 0);
        blk_mode = 1;
        step(0, 0, 0, 0, 0);
        chk("R9 held after mode switch", int'(rx_rdy_n), 0);
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        chk("R9 release on empty", int'(rx_rdy_n), 1);
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        chk("R8 trigger reached", int'(rx_rdy_n), 0);
        step(0, 1, 0, 0, 0);
        step(0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        chk("R9 hold below trigger", int'(rx_rdy_n), 0);
        step(0, 1, 0, 0, 0);
        step(0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        chk("R9 empty releases", int'(rx_rdy_n), 1);

        // R11 and R8 timeout path
        step(0, 0, 0, 0, 1);
        chk("R11 timeout empty", int'(rx_rdy_n), 1);
        step(1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        chk("R8 one byte no timeout", int'(rx_rdy_n), 1);
        step(0, 0, 0, 0, 1);
        chk("R8 timeout with data", int'(rx_rdy_n), 0);
        step(0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0);

        // R10: transmit full in block mode
        for (int i = 0; i < 32; i++) step(0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0);
        chk("R10 tx full", int'(tx_rdy_n), 1);
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0);
        chk("R10 one slot free", int'(tx_rdy_n), 0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 64) == 0) blk_mode = ~blk_mode;
            if (($urandom % 128) == 0) rx_trig = 8'($urandom % 40);
            if (($urandom % 256) == 0)
                cfg_rx_lvl = (($urandom % 2) == 0) ? 8'h00 : 8'h10;
            step(($urandom % 4) < 2, ($urandom % 4) == 0,
                 ($urandom % 3) == 0, ($urandom % 3) == 0,
                 ($urandom % 16) == 0);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule